// File: doc/BRIEF.md
# Masked GPIO Port Register File

This block is the register file behind one 32-pin general-purpose I/O port on a simple memory-mapped bus. Software uses it to pick which pins drive and which only listen, to hide pins from later accesses, and to change output levels. It drives the output levels and output enables toward the pads. It also brings the pad levels back, through a two-flop synchronizer, so software can read them.

The output latch can be changed in three ways. A set write raises every bit written as 1. A clear write lowers every bit written as 1. A write to the pin-value word loads the written bits directly. With set and clear, software changes single bits without a read-modify-write. A per-pin mask register shuts pins off from all three kinds of change and hides them from pin-value reads. A per-pin analog-select input cuts a pin off from the digital side entirely. Every register accepts byte, halfword and word writes through four byte enables.

Top module: `mgpio_port`

## Requirements
- R1: After reset the direction, mask and output-latch registers are all zero, so `pad_oe` and `pad_out` are zero and reads of words 0, 4 and 6 return zero.
- R2: A direction bit of 1 makes that pin an output. `pad_oe[i]` equals the direction bit and `pad_out[i]` equals the latch bit, unless the pin is analog-selected.
- R3: A pin whose mask bit is 1 ignores pin-value writes, set writes and clear writes, and reads back as 0 from the pin-value word.
- R4: A set write (word 6) raises each latch bit written as 1. A clear write (word 7) lowers each latch bit written as 1. Bits written as 0 keep their value in both cases.
- R5: Set and clear writes leave latch bits of input pins (direction 0) unchanged.
- R6: When set and clear writes hit the same bit in turn, the later write decides its value. No other access is needed between them.
- R7: `bus_word` selects a 32-bit word: 0 direction, 4 mask, 5 pin value, 6 set, 7 clear. A read of word 6 returns the output latch. Reads of word 7 and of the unmapped words 1 to 3 return 0.
- R8: `bus_be[k]` enables bits 8k+7..8k of a write. Bits in lanes that are not enabled keep their value, so a byte write with only `bus_be[3]` set changes bits 31:24 alone.
- R9: `bus_rdata` is registered. It carries the word read one cycle after `bus_rd`. A pin-value read whose strobe is taken at the first or second rising edge after a pad change returns the old level. From the third edge on, it returns the new level.
- R10: An analog-selected pin reads as 0 from the pin-value word. Its `pad_oe` and `pad_out` are 0, and pin-value, set and clear writes leave its latch bit unchanged.
- R11: A pin-value write (word 5) loads the written data into the latch bits that are unmasked and not analog-selected, whatever their direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_word | input | 3 | Word select within the port |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels |
| ana_sel | input | 32 | Per-pin analog select, detaches the pin |
| pad_out | output | 32 | Output levels to pads |
| pad_oe | output | 32 | Output enables to pads |

## Verification
The assertions assume three things about the inputs. `bus_wr` and `bus_rd` are never high in the same cycle. `ana_sel` is a static configuration that changes only while no access is in flight. `pad_in` may change at any cycle. The bench drives one strobe at a time on falling edges and changes `ana_sel` only between accesses. Pad inputs are allowed to change right before a read, to exercise the synchronizer latency.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  localparam int WORD_SEL_W = 3;
  localparam logic [WORD_SEL_W-1:0] WSEL_DIR  = 3'd0;
  localparam logic [WORD_SEL_W-1:0] WSEL_MASK = 3'd4;
  localparam logic [WORD_SEL_W-1:0] WSEL_PIN  = 3'd5;
  localparam logic [WORD_SEL_W-1:0] WSEL_SET  = 3'd6;
  localparam logic [WORD_SEL_W-1:0] WSEL_CLR  = 3'd7;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WORD_SEL_W-1:0] sel,
  input  logic [W-1:0]          wdata,
  input  logic [W-1:0]          lanes,
  input  logic [W-1:0]          ana_sel,
  output logic [W-1:0]          dir_q,
  output logic [W-1:0]          mask_q,
  output logic [W-1:0]          out_q,
  output logic [W-1:0]          set_eff,
  output logic [W-1:0]          clr_eff,
  output logic [W-1:0]          pin_upd
);
  // bits a set/clear write may touch: written 1, enabled lane, output, reachable
  function automatic logic [W-1:0] strobe_bits(
    input logic [W-1:0] wd, input logic [W-1:0] ln, input logic [W-1:0] dir,
    input logic [W-1:0] msk, input logic [W-1:0] ana);
    return wd & ln & dir & ~msk & ~ana;
  endfunction

  // bits a direct pin-value write may load
  function automatic logic [W-1:0] load_bits(
    input logic [W-1:0] ln, input logic [W-1:0] msk, input logic [W-1:0] ana);
    return ln & ~msk & ~ana;
  endfunction

  function automatic logic [W-1:0] merge(
    input logic [W-1:0] old_v, input logic [W-1:0] new_v, input logic [W-1:0] en);
    return (old_v & ~en) | (new_v & en);
  endfunction

  logic wr_dir, wr_mask, wr_pin, wr_set, wr_clr;
  assign wr_dir  = wr_en && (sel == WSEL_DIR);
  assign wr_mask = wr_en && (sel == WSEL_MASK);
  assign wr_pin  = wr_en && (sel == WSEL_PIN);
  assign wr_set  = wr_en && (sel == WSEL_SET);
  assign wr_clr  = wr_en && (sel == WSEL_CLR);

  assign set_eff = wr_set ? strobe_bits(wdata, lanes, dir_q, mask_q, ana_sel) : '0;
  assign clr_eff = wr_clr ? strobe_bits(wdata, lanes, dir_q, mask_q, ana_sel) : '0;
  assign pin_upd = wr_pin ? load_bits(lanes, mask_q, ana_sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else begin
      if (wr_dir)  dir_q  <= merge(dir_q, wdata, lanes);
      if (wr_mask) mask_q <= merge(mask_q, wdata, lanes);
      out_q <= (merge(out_q, wdata, pin_upd) | set_eff) & ~clr_eff;
    end
  end
endmodule

// File: rtl/mgpio_rdmux.sv
module mgpio_rdmux
  import mgpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [WORD_SEL_W-1:0] sel,
  input  logic [W-1:0]          dir_q,
  input  logic [W-1:0]          mask_q,
  input  logic [W-1:0]          out_q,
  input  logic [W-1:0]          pin_sync,
  input  logic [W-1:0]          ana_sel,
  output logic [W-1:0]          rdata
);
  function automatic logic [W-1:0] visible_pins(
    input logic [W-1:0] lvl, input logic [W-1:0] msk, input logic [W-1:0] ana);
    return lvl & ~msk & ~ana;
  endfunction

  logic [W-1:0] rd_word;

  always_comb begin
    case (sel)
      WSEL_DIR:  rd_word = dir_q;
      WSEL_MASK: rd_word = mask_q;
      WSEL_PIN:  rd_word = visible_pins(pin_sync, mask_q, ana_sel);
      WSEL_SET:  rd_word = out_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int W         = 32,
  parameter int SYNC_DEPTH = 2,
  localparam int LANES    = W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_SEL_W-1:0] bus_word,
  input  logic [W-1:0]          bus_wdata,
  input  logic [LANES-1:0]      bus_be,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [W-1:0]          bus_rdata,
  input  logic [W-1:0]          pad_in,
  input  logic [W-1:0]          ana_sel,
  output logic [W-1:0]          pad_out,
  output logic [W-1:0]          pad_oe
);
  function automatic logic [W-1:0] expand_lanes(input logic [LANES-1:0] be);
    logic [W-1:0] m;
    for (int k = 0; k < LANES; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  logic [W-1:0] lane_mask;
  logic [W-1:0] dir_q, mask_q, out_q, pin_sync;
  logic [W-1:0] set_eff, clr_eff, pin_upd;

  assign lane_mask = expand_lanes(bus_be);

  mgpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_sync(pin_sync));

  mgpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(bus_word),
    .wdata(bus_wdata), .lanes(lane_mask), .ana_sel(ana_sel),
    .dir_q(dir_q), .mask_q(mask_q), .out_q(out_q),
    .set_eff(set_eff), .clr_eff(clr_eff), .pin_upd(pin_upd));

  mgpio_rdmux #(.W(W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .sel(bus_word),
    .dir_q(dir_q), .mask_q(mask_q), .out_q(out_q), .pin_sync(pin_sync),
    .ana_sel(ana_sel), .rdata(bus_rdata));

  assign pad_oe  = dir_q & ~ana_sel;
  assign pad_out = out_q & ~ana_sel;
endmodule

// File: rtl/mgpio_checker.sv
module mgpio_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   word,
  input logic [W-1:0] lanes,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] out_q,
  input logic [W-1:0] ana_sel,
  input logic [W-1:0] rdata
);
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_q ^ $past(out_q)) & $past(mask_q)) == '0); // R3

  AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == 3'd5) |=> (rdata & $past(mask_q)) == '0); // R3

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 3'd6) |=> ($past(out_q) & ~out_q) == '0); // R4

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 3'd7) |=> (out_q & ~$past(out_q)) == '0); // R4

  AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && word == 3'd5) |=> ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0); // R5

  AST_DIR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 3'd0) |=> ((dir_q ^ $past(dir_q)) & ~$past(lanes)) == '0); // R8

  AST_ANALOG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == 3'd5) |=> (rdata & $past(ana_sel)) == '0); // R10

  AST_ANALOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_q ^ $past(out_q)) & $past(ana_sel)) == '0); // R10
endmodule

bind mgpio_port mgpio_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd), .word(bus_word),
  .lanes(lane_mask), .dir_q(dir_q), .mask_q(mask_q), .out_q(out_q),
  .ana_sel(ana_sel), .rdata(bus_rdata));

// File: tb/mgpio_port_bench.sv
module mgpio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] ana_sel = '0;
  logic [31:0] pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  logic [31:0] m_dir = '0, m_mask = '0, m_out = '0;

  always #2 clk = ~clk;

  mgpio_port u_mgpio_port (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .ana_sel(ana_sel), .pad_out(pad_out), .pad_oe(pad_oe));

  function automatic logic [31:0] lane_bits(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (be[k]) m = m | (32'hFF << (8 * k));
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write, updating the bench model from the requirements
  task automatic wr(input logic [2:0] w, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] ln = lane_bits(be);
    logic [31:0] ok = ~m_mask & ~ana_sel;
    case (w)
      3'd0: m_dir  = (m_dir & ~ln) | (d & ln);
      3'd4: m_mask = (m_mask & ~ln) | (d & ln);
      3'd5: m_out  = (m_out & ~(ln & ok)) | (d & ln & ok);
      3'd6: m_out  = m_out | (d & ln & ok & m_dir);
      3'd7: m_out  = m_out & ~(d & ln & ok & m_dir);
      default: ;
    endcase
    bus_word = w; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    bus_word = w; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_pads(input string req);
    logic [31:0] v;
    chk(req, pad_oe, m_dir & ~ana_sel);
    chk(req, pad_out, m_out & ~ana_sel);
    rd(3'd6, v);
    chk(req, v, m_out);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", pad_oe, 32'h0);
    chk("R1", pad_out, 32'h0);
    rd(3'd0, v); chk("R1", v, 32'h0);
    rd(3'd4, v); chk("R1", v, 32'h0);
    rd(3'd6, v); chk("R1", v, 32'h0);

    // R8 R2 sweep all byte-enable patterns on the direction word
    for (int b = 0; b < 16; b++) begin
      wr(3'd0, 32'h0, 4'hF);
      wr(3'd0, 32'hFFFF_FFFF, 4'(b));
      rd(3'd0, v); chk("R8", v, lane_bits(4'(b)));
      chk("R2", pad_oe, lane_bits(4'(b)));
    end

    // R4 set/clear over all outputs
    wr(3'd0, 32'hFFFF_FFFF, 4'hF);
    wr(3'd6, 32'hFFFF_FFFF, 4'hF); check_pads("R4");
    chk("R4", pad_out, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0, 4'hF); check_pads("R4");
    wr(3'd7, 32'h0000_FFFF, 4'hF); check_pads("R4");
    chk("R4", pad_out, 32'hFFFF_0000);
    wr(3'd7, 32'h0, 4'hF); check_pads("R4");

    // R5 set/clear on inputs ignored, per-bit sweep
    wr(3'd0, 32'h00FF_00FF, 4'hF);
    for (int i = 0; i < 32; i++) begin
      wr(3'd6, 32'h1 << i, 4'hF); check_pads("R5");
    end
    for (int i = 0; i < 32; i++) begin
      wr(3'd7, 32'h1 << i, 4'hF); check_pads("R5");
    end

    // R6 last write wins
    wr(3'd0, 32'hFFFF_FFFF, 4'hF);
    wr(3'd6, 32'h8000_0001, 4'hF);
    wr(3'd7, 32'h8000_0001, 4'hF); check_pads("R6");
    chk("R6", pad_out & 32'h8000_0001, 32'h0);
    wr(3'd6, 32'h8000_0001, 4'hF); check_pads("R6");
    chk("R6", pad_out & 32'h8000_0001, 32'h8000_0001);

    // R3 mask gates set/clear/pin writes and pin reads
    wr(3'd4, 32'h0F0F_0F0F, 4'hF);
    for (int i = 0; i < 32; i++) begin
      wr(3'd7, 32'h1 << i, 4'hF); check_pads("R3");
      wr(3'd5, ~m_out, 4'hF); check_pads("R3");
    end
    pad_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R3", v, 32'hF0F0_F0F0);

    // R11 pin-value write with lanes, regardless of direction
    wr(3'd0, 32'h0000_0000, 4'hF);
    wr(3'd5, 32'hA5A5_A5A5, 4'b0101); check_pads("R11");
    wr(3'd5, 32'h5A5A_5A5A, 4'hF); check_pads("R11");
    wr(3'd4, 32'h0, 4'hF);
    wr(3'd5, 32'h1234_5678, 4'b1000); check_pads("R11");
    rd(3'd6, v); chk("R11", v & 32'hFF00_0000, 32'h1200_0000);

    // R7 address map reads
    rd(3'd4, v); chk("R7", v, m_mask);
    rd(3'd7, v); chk("R7", v, 32'h0);
    for (int w = 1; w < 4; w++) begin
      rd(3'(w), v); chk("R7", v, 32'h0);
    end

    // R9 synchronizer latency: old, old, new
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    pad_in = 32'hC3C3_3C3C;
    rd(3'd5, v); chk("R9", v, 32'h0);
    rd(3'd5, v); chk("R9", v, 32'h0);
    rd(3'd5, v); chk("R9", v, 32'hC3C3_3C3C);

    // R10 analog pins detached
    wr(3'd0, 32'hFFFF_FFFF, 4'hF);
    wr(3'd6, 32'hFFFF_FFFF, 4'hF);
    ana_sel = 32'h0000_00F0;
    @(negedge clk);
    pad_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R10", v, 32'hFFFF_FF0F);
    chk("R10", pad_oe, 32'hFFFF_FF0F);
    wr(3'd7, 32'hFFFF_FFFF, 4'hF);
    wr(3'd5, 32'h0, 4'hF);
    check_pads("R10");
    ana_sel = 32'h0;
    @(negedge clk);
    chk("R10", pad_out, 32'h0000_00F0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule